// File: doc/BRIEF.md
# Two-Thread Congestion Throttle Controller

This block sits beside the decode stage of a core that runs two hardware threads at once. It decides when one thread is hogging shared resources and holding back its sibling. Each cycle it receives a level-2 cache miss pulse and a TLB miss pulse for each thread, plus the number of reorder-buffer entries that each thread occupies. It counts the misses over a repeating window of cycles. A thread is congested when either of its miss counts reaches its programmed threshold, or when its reorder-buffer occupancy goes above a programmed limit.

Only one thread is throttled at a time, and it is always a congested thread. The programmed policy selects one of three actions. The first blocks decode. The second issues a one-cycle request to discard that thread's instructions waiting for dispatch, then blocks decode. The third only asks for a lower decode rate. The action chosen on entry is held for as long as the thread stays selected, and it is released in the cycle after that ends. The block only produces the control signals. Flushing, decode gating and the caches are handled elsewhere.

Top module: `smt_throttle_ctrl`

## Requirements
- R1: After reset, every stall, flush and rate-reduction output is low.
- R2: A thread is congested when its reorder-buffer count is strictly greater than `cfg_rob_limit`. A count equal to the limit does not count. The throttle output is visible in the cycle after the count is presented.
- R3: A thread is congested when its L2 miss count for the current window is greater than or equal to `cfg_l2_limit`. The throttle output follows one cycle after the count reaches the threshold. A threshold of 0 disables this source.
- R4: A thread is congested when its TLB miss count for the current window is greater than or equal to `cfg_tlb_limit`. The timing is the same as in R3, and a threshold of 0 disables this source.
- R5: A window timer starts at 0 after reset and counts to `cfg_window`-1. In that last cycle both threads' miss counts are cleared, and any miss arriving in that cycle is dropped. Miss counts saturate.
- R6: Policy code 0, and also code 3, raises `decode_stall_o` for the throttled thread, with no flush and no rate hint.
- R7: Policy code 1 raises `flush_req_o` in the first throttled cycle only. `decode_stall_o` stays high for the whole hold, and the flush is never repeated while the hold lasts.
- R8: Policy code 2 raises `rate_cut_o` for the throttled thread and leaves `decode_stall_o` low.
- R9: The action is latched when the hold begins, so later policy changes do not affect it. All outputs of that thread drop in the cycle after it stops being selected.
- R10: Only a congested thread is throttled. The sibling's outputs stay low.
- R11: When both threads are congested, only the one with the larger reorder-buffer count is throttled. On equal counts, thread 1 (bit 1 of each output) is throttled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l2_miss_i | input | 2 | L2 miss pulse, one bit per thread |
| tlb_miss_i | input | 2 | TLB miss pulse, one bit per thread |
| rob_used_t0_i | input | ROB_W | Reorder-buffer entries held by thread 0 |
| rob_used_t1_i | input | ROB_W | Reorder-buffer entries held by thread 1 |
| cfg_l2_limit | input | CNT_W | L2 miss threshold (0 disables) |
| cfg_tlb_limit | input | CNT_W | TLB miss threshold (0 disables) |
| cfg_rob_limit | input | ROB_W | Occupancy limit, exceeded means congested |
| cfg_window | input | WIN_W | Miss counting window length in cycles |
| cfg_policy | input | 2 | 0/3 stall, 1 flush-and-hold, 2 rate reduction |
| decode_stall_o | output | 2 | Block decode, per thread |
| flush_req_o | output | 2 | One-cycle flush request, per thread |
| rate_cut_o | output | 2 | Lower decode rate hint, per thread |

## Verification
Suppose a miss counter fails to clear at the window edge. The damage shows only when a later window's misses cross the threshold, so the bench splits misses across a known window boundary. A wrong arbitration choice or a hold that is not latched shows on the outputs one cycle after the inputs change, because every output comes from a register. A stuck flush state shows as a second `flush_req_o` pulse within the same hold. Each stimulus is therefore checked both on the first throttled cycle and on the cycle after it.

// File: rtl/thr_pkg.sv
package thr_pkg;

  localparam int NUM_THR = 2;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_STALL = 2'd1,
    ACT_FLUSH = 2'd2,
    ACT_RATE  = 2'd3
  } act_e;

  // Map a programmed policy code onto the action taken on entry.
  function automatic act_e policy_to_act(input logic [1:0] code);
    case (code)
      2'd1:    return ACT_FLUSH;
      2'd2:    return ACT_RATE;
      default: return ACT_STALL;
    endcase
  endfunction

  function automatic logic act_blocks_decode(input act_e a);
    return (a == ACT_STALL) || (a == ACT_FLUSH);
  endfunction

endpackage

// File: rtl/thr_win_timer.sv
module thr_win_timer #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] cfg_window,
  output logic             win_end_o
);

  logic [WIN_W-1:0] win_cnt;

  // Last cycle of a window; lengths 0 and 1 both end every cycle.
  function automatic logic is_last(input logic [WIN_W-1:0] cnt,
                                   input logic [WIN_W-1:0] len);
    if (len <= WIN_W'(1)) return 1'b1;
    return cnt >= (len - WIN_W'(1));
  endfunction

  assign win_end_o = is_last(win_cnt, cfg_window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_cnt <= '0;
    else if (win_end_o) win_cnt <= '0;
    else                win_cnt <= win_cnt + WIN_W'(1);
  end

  // R5
  win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_o |=> (win_cnt == '0));

endmodule

// File: rtl/thr_miss_cnt.sv
module thr_miss_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] cnt_o
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_o <= '0;
    else if (win_end_i) cnt_o <= '0;
    else if (miss_i)    cnt_o <= sat_inc(cnt_o);
  end

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_i |=> (cnt_o == '0));

  // R5
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end_i |=> (cnt_o >= $past(cnt_o)));

endmodule

// File: rtl/thr_offend_arb.sv
module thr_offend_arb #(
  parameter int CNT_W = 6,
  parameter int ROB_W = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [thr_pkg::NUM_THR-1:0][CNT_W-1:0] l2_cnt_i,
  input  logic [thr_pkg::NUM_THR-1:0][CNT_W-1:0] tlb_cnt_i,
  input  logic [thr_pkg::NUM_THR-1:0][ROB_W-1:0] rob_i,
  input  logic [CNT_W-1:0]                    cfg_l2_limit,
  input  logic [CNT_W-1:0]                    cfg_tlb_limit,
  input  logic [ROB_W-1:0]                    cfg_rob_limit,
  output logic [thr_pkg::NUM_THR-1:0]         offend_o,
  output logic [thr_pkg::NUM_THR-1:0]         target_o
);

  function automatic logic hits_limit(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] lim);
    return (lim != '0) && (cnt >= lim);
  endfunction

  // Both congested: larger occupancy loses its turn at decode; tie to thread 1.
  function automatic logic [1:0] pick(input logic [1:0]       off,
                                      input logic [ROB_W-1:0] r0,
                                      input logic [ROB_W-1:0] r1);
    if (off == 2'b11) return (r0 > r1) ? 2'b01 : 2'b10;
    return off;
  endfunction

  for (genvar t = 0; t < thr_pkg::NUM_THR; t++) begin : g_off
    assign offend_o[t] = hits_limit(l2_cnt_i[t], cfg_l2_limit)  ||
                         hits_limit(tlb_cnt_i[t], cfg_tlb_limit) ||
                         (rob_i[t] > cfg_rob_limit);

    // R10
    target_needs_offend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      target_o[t] |-> offend_o[t]);
  end

  assign target_o = pick(offend_o, rob_i[0], rob_i[1]);

  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(target_o));

  // R11
  both_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offend_o == 2'b11) |-> (target_o != 2'b00));

endmodule

// File: rtl/thr_action_fsm.sv
module thr_action_fsm
  import thr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       target_i,
  input  logic [1:0] cfg_policy,
  output logic       decode_stall_o,
  output logic       flush_req_o,
  output logic       rate_cut_o
);

  act_e state, state_nx;
  logic entering;
  logic flush_q;

  assign entering = target_i && (state == ACT_IDLE);

  always_comb begin
    if (!target_i)     state_nx = ACT_IDLE;
    else if (entering) state_nx = policy_to_act(cfg_policy);
    else               state_nx = state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ACT_IDLE;
      flush_q <= 1'b0;
    end else begin
      state   <= state_nx;
      flush_q <= entering && (policy_to_act(cfg_policy) == ACT_FLUSH);
    end
  end

  assign decode_stall_o = act_blocks_decode(state);
  assign rate_cut_o     = (state == ACT_RATE);
  assign flush_req_o    = flush_q;

  // R7
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |=> !flush_req_o);

  // R7
  flush_with_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |-> decode_stall_o);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !target_i |=> !(decode_stall_o || rate_cut_o || flush_req_o));

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_stall_o && target_i) |=> decode_stall_o);

  // R8
  rate_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_cut_o |-> !decode_stall_o);

endmodule

// File: rtl/smt_throttle_ctrl.sv
module smt_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int ROB_W = 7,
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       l2_miss_i,
  input  logic [1:0]       tlb_miss_i,
  input  logic [ROB_W-1:0] rob_used_t0_i,
  input  logic [ROB_W-1:0] rob_used_t1_i,
  input  logic [CNT_W-1:0] cfg_l2_limit,
  input  logic [CNT_W-1:0] cfg_tlb_limit,
  input  logic [ROB_W-1:0] cfg_rob_limit,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [1:0]       cfg_policy,
  output logic [1:0]       decode_stall_o,
  output logic [1:0]       flush_req_o,
  output logic [1:0]       rate_cut_o
);

  logic                             win_end;
  logic [NUM_THR-1:0][CNT_W-1:0]    l2_cnt;
  logic [NUM_THR-1:0][CNT_W-1:0]    tlb_cnt;
  logic [NUM_THR-1:0][ROB_W-1:0]    rob_used;
  logic [NUM_THR-1:0]               offend;
  logic [NUM_THR-1:0]               target;
  logic [NUM_THR-1:0]               throttled;

  assign rob_used[0] = rob_used_t0_i;
  assign rob_used[1] = rob_used_t1_i;

  thr_win_timer #(.WIN_W(WIN_W)) i_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_window(cfg_window),
    .win_end_o (win_end)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    thr_miss_cnt #(.CNT_W(CNT_W)) i_l2_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .miss_i   (l2_miss_i[t]),
      .win_end_i(win_end),
      .cnt_o    (l2_cnt[t])
    );

    thr_miss_cnt #(.CNT_W(CNT_W)) i_tlb_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .miss_i   (tlb_miss_i[t]),
      .win_end_i(win_end),
      .cnt_o    (tlb_cnt[t])
    );

    thr_action_fsm i_act (
      .clk           (clk),
      .rst_n         (rst_n),
      .target_i      (target[t]),
      .cfg_policy    (cfg_policy),
      .decode_stall_o(decode_stall_o[t]),
      .flush_req_o   (flush_req_o[t]),
      .rate_cut_o    (rate_cut_o[t])
    );

    assign throttled[t] = decode_stall_o[t] || rate_cut_o[t];
  end

  thr_offend_arb #(.CNT_W(CNT_W), .ROB_W(ROB_W)) i_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .l2_cnt_i     (l2_cnt),
    .tlb_cnt_i    (tlb_cnt),
    .rob_i        (rob_used),
    .cfg_l2_limit (cfg_l2_limit),
    .cfg_tlb_limit(cfg_tlb_limit),
    .cfg_rob_limit(cfg_rob_limit),
    .offend_o     (offend),
    .target_o     (target)
  );

  // R10
  one_throttled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(throttled));

  // R10
  onset_needs_offend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (target != 2'b00) |-> (offend != 2'b00));

endmodule

// File: tb/test_smt_throttle_ctrl.sv
module test_smt_throttle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;
  localparam int ROB_W = 7;
  localparam int WIN_W = 10;
  localparam int LIMIT = 40;
  localparam int NVEC  = 10;

  // rob0, rob1, policy code
  localparam int VEC[NVEC][3] = '{
    '{41, 0, 0}, '{40, 0, 0}, '{0, 50, 1}, '{0, 41, 2}, '{60, 50, 0},
    '{50, 60, 1}, '{55, 55, 0}, '{45, 45, 2}, '{0, 0, 3}, '{70, 40, 3}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       l2_miss = '0, tlb_miss = '0;
  logic [ROB_W-1:0] rob0 = '0, rob1 = '0;
  logic [CNT_W-1:0] l2_lim = '0, tlb_lim = '0;
  logic [ROB_W-1:0] rob_lim = ROB_W'(LIMIT);
  logic [WIN_W-1:0] win = WIN_W'(1000);
  logic [1:0]       pol = '0;
  logic [1:0]       stall, flush, rate;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_throttle_ctrl #(.CNT_W(CNT_W), .ROB_W(ROB_W), .WIN_W(WIN_W)) i_smt_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .l2_miss_i(l2_miss), .tlb_miss_i(tlb_miss),
    .rob_used_t0_i(rob0), .rob_used_t1_i(rob1), .cfg_l2_limit(l2_lim),
    .cfg_tlb_limit(tlb_lim), .cfg_rob_limit(rob_lim), .cfg_window(win),
    .cfg_policy(pol), .decode_stall_o(stall), .flush_req_o(flush), .rate_cut_o(rate)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Output word {rate, flush, stall} as a 6-bit number
  function automatic int outs(input logic [1:0] s, input logic [1:0] f, input logic [1:0] r);
    return int'({r, f, s});
  endfunction

  function automatic int model(input int r0, input int r1, input int p, input bit first);
    bit o0, o1;
    logic [1:0] tg, s, f, r;
    o0 = r0 > LIMIT;
    o1 = r1 > LIMIT;
    tg[0] = o0 && (!o1 || r0 > r1);
    tg[1] = o1 && (!o0 || r1 >= r0);
    s = (p != 2) ? tg : 2'b00;
    r = (p == 2) ? tg : 2'b00;
    f = (p == 1 && first) ? tg : 2'b00;
    return int'({r, f, s});
  endfunction

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs after reset", outs(stall, flush, rate), 0);

    // Table walk: R2 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      rob0 = ROB_W'(VEC[v][0]);
      rob1 = ROB_W'(VEC[v][1]);
      pol  = 2'(VEC[v][2]);
      @(negedge clk);
      chk($sformatf("R2/R6/R7/R8/R11 vec%0d first", v), outs(stall, flush, rate),
          model(VEC[v][0], VEC[v][1], VEC[v][2], 1'b1));
      @(negedge clk);
      chk($sformatf("R7/R10 vec%0d hold", v), outs(stall, flush, rate),
          model(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0));
      rob0 = '0;
      rob1 = '0;
      @(negedge clk);
      chk($sformatf("R9 vec%0d release", v), outs(stall, flush, rate), 0);
    end

    // R3 L2 threshold on thread 1
    l2_lim = 6'd3;
    pol = 2'd0;
    do_reset();
    l2_miss = 2'b10;
    repeat (3) @(negedge clk);
    l2_miss = 2'b00;
    chk("R3 not before latency", int'(stall), 0);
    @(negedge clk);
    chk("R3 R10 thread1 stalled only", int'(stall), 2);

    // R3 zero threshold disables
    l2_lim = 6'd0;
    do_reset();
    l2_miss = 2'b11;
    repeat (5) @(negedge clk);
    l2_miss = 2'b00;
    @(negedge clk);
    chk("R3 zero threshold disabled", int'(stall), 0);

    // R4 TLB threshold on thread 0, rate policy
    tlb_lim = 6'd2;
    pol = 2'd2;
    do_reset();
    tlb_miss = 2'b01;
    repeat (2) @(negedge clk);
    tlb_miss = 2'b00;
    @(negedge clk);
    chk("R4 R8 thread0 rate cut", outs(stall, flush, rate), int'({2'b01, 2'b00, 2'b00}));
    tlb_lim = 6'd0;
    @(negedge clk);
    chk("R9 released after TLB source disabled", outs(stall, flush, rate), 0);

    // R5 window clears counts: window 8, misses 2+2 across boundary, threshold 3
    l2_lim = 6'd3;
    pol = 2'd0;
    win = WIN_W'(8);
    do_reset();
    for (int c = 0; c < 12; c++) begin
      l2_miss[0] = (c == 4 || c == 5 || c == 8 || c == 9);
      @(negedge clk);
    end
    l2_miss = 2'b00;
    @(negedge clk);
    chk("R5 counts cleared at window end", int'(stall), 0);
    // Same four misses inside one window do stall
    do_reset();
    for (int c = 0; c < 5; c++) begin
      l2_miss[0] = (c >= 1);
      @(negedge clk);
    end
    l2_miss = 2'b00;
    chk("R5 misses in one window accumulate", int'(stall), 1);
    l2_lim = 6'd0;
    win = WIN_W'(1000);

    // R9 mode latched while held; R7 single flush over long hold
    do_reset();
    pol = 2'd0;
    rob0 = 7'd90;
    @(negedge clk);
    pol = 2'd2;
    repeat (2) @(negedge clk);
    chk("R9 mode latched at entry", outs(stall, flush, rate), 1);
    rob0 = '0;
    @(negedge clk);
    pol = 2'd1;
    rob1 = 7'd90;
    begin
      int pulses = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (flush[1]) pulses++;
      end
      chk("R7 one flush per hold", pulses, 1);
    end
    chk("R7 stall held during flush hold", int'(stall), 2);
    rob1 = '0;
    @(negedge clk);
    chk("R9 flush hold released", outs(stall, flush, rate), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule